// File: doc/BRIEF.md
# Receive FIFO flow-control pause requester

This block sits beside a MAC receive FIFO. It decides when the MAC transmitter should emit an IEEE 802.3x pause frame, and it chooses the pause time to carry: all ones (FFFFh) to stop the link partner, or zero to let it resume. Two automatic sources feed the decision. One is the FIFO filling past a programmable level; the other is the receive descriptor supply running dry. A mode input joins these two sources by AND or by OR. Software can also trigger a frame by hand through two self-clearing control bits, one for each pause time.

The request is held towards the transmitter until the transmitter acknowledges it with a one-cycle done pulse. One further event can wait in a single pending slot behind the request that is being held. Separately, the block raises a one-cycle early-receive interrupt once the current frame has grown to a chosen number of eighths of the FIFO capacity.

Top module: `rx_pause_ctrl`

## Requirements
- R1: The FIFO counts as near overflow when `fifo_level >= 32 * near_thresh`. A `near_thresh` of 0 disables near-overflow detection.
- R2: When `auto_fifo_en` is 1 and the combined automatic condition rises, an FFFFh request is raised two clock edges later if the output is idle. A condition that stays active raises no further request until it has first gone inactive and then become active again.
- R3: When `auto_fifo_en` is 1 and `fifo_level` changes from nonzero to 0, a request with pause time 0000h is raised.
- R4: When `auto_desc_en` is 1, `desc_unavail` acts as the second automatic condition. A disabled source always counts as inactive.
- R5: With `either_mode` at 1, either automatic condition alone raises an FFFFh request. With `either_mode` at 0, both conditions must be active in the same cycle.
- R6: A `set_max` pulse sets `man_max_q` on the next edge and raises an FFFFh request. `man_max_q` clears on the edge where `tx_done` acknowledges a held request whose time is FFFFh.
- R7: A `set_zero` pulse sets `man_zero_q` and raises a 0000h request. `man_zero_q` clears when a held 0000h request is acknowledged.
- R8: A 0000h event is dropped while the FIFO is near overflow and an FFFFh event is pending or arrives in the same cycle. When both arrive in the same cycle and the FIFO is not near overflow, the 0000h event is kept and the FFFFh event is dropped. Otherwise the newest event replaces the pending one.
- R9: `pause_req` stays at 1 with `pause_time` stable until `tx_done`. On the edge that samples `tx_done`, `pause_req` goes to 0. A pending event is presented one edge later.
- R10: With `erx_sel` nonzero, `erx_irq` pulses for exactly one cycle, on the edge after the first cycle in which `8 * frame_bytes >= erx_sel * fifo_capacity`. It fires at most once per frame and re-arms on `frame_start`. With `erx_sel` at 0 it never fires.
- R11: A synchronous active-high `rst` clears `pause_req`, `pause_time`, `erx_irq`, `man_max_q`, `man_zero_q`, the pending slot and all edge-detect state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | CNT_W | Bytes currently held in the receive FIFO |
| fifo_capacity | input | CNT_W | Total FIFO size in bytes |
| frame_start | input | 1 | Pulse marking the start of a received frame |
| frame_bytes | input | CNT_W | Bytes of the current frame received so far |
| desc_unavail | input | 1 | No receive descriptor is available |
| near_thresh | input | 6 | Near-overflow level in units of 32 bytes |
| erx_sel | input | 3 | Early-receive threshold in eighths of capacity, 0 disables |
| auto_fifo_en | input | 1 | Enables the FIFO-level trigger (FFFFh when near, 0000h when empty) |
| auto_desc_en | input | 1 | Enables the descriptor-unavailable trigger |
| either_mode | input | 1 | 1: automatic triggers ORed, 0: ANDed |
| set_max | input | 1 | Pulse that sets the manual FFFFh control bit |
| set_zero | input | 1 | Pulse that sets the manual 0000h control bit |
| tx_done | input | 1 | One-cycle acknowledgement that the pause frame was sent |
| pause_req | output | 1 | Pause frame request to the transmitter |
| pause_time | output | TIME_W | Pause time to place in the frame |
| erx_irq | output | 1 | Early-receive interrupt pulse |
| man_max_q | output | 1 | Manual FFFFh control bit |
| man_zero_q | output | 1 | Manual 0000h control bit |

## Verification
The bench holds the FIFO above the threshold across an acknowledge and expects silence. A level-triggered design would instead send pause frames over and over. It sets the near-overflow level one byte above and then exactly at the FIFO count, and it sets the threshold field to zero while the FIFO is full. An off-by-one comparator, or a zero field read as "always near", would show up in these cases. A 0000h request issued while an FFFFh event waits behind a busy output must vanish. A same-cycle tie below the threshold must resolve to 0000h, so a design with a fixed priority, or one that queues both events, would emit the wrong time or an extra frame. The early-receive checks look for a pulse that lasts one cycle, fires once per frame, re-arms on a new frame and stays quiet when disabled.

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl #(
  parameter int CNT_W  = 12,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic [CNT_W-1:0]  fifo_capacity,
  input  logic              frame_start,
  input  logic [CNT_W-1:0]  frame_bytes,
  input  logic              desc_unavail,
  input  logic [5:0]        near_thresh,
  input  logic [2:0]        erx_sel,
  input  logic              auto_fifo_en,
  input  logic              auto_desc_en,
  input  logic              either_mode,
  input  logic              set_max,
  input  logic              set_zero,
  input  logic              tx_done,
  output logic              pause_req,
  output logic [TIME_W-1:0] pause_time,
  output logic              erx_irq,
  output logic              man_max_q,
  output logic              man_zero_q
);
  localparam int LW = CNT_W + 6;
  localparam int EW = CNT_W + 3;
  localparam logic [TIME_W-1:0] TMAX = {TIME_W{1'b1}};

  logic comb_q, nonempty_q, slot_v, slot_max, erx_fired;

  wire [LW-1:0] near_lvl = LW'({near_thresh, 5'b0});
  wire near = (near_thresh != 6'd0) && (LW'(fifo_level) >= near_lvl);

  wire trig_fifo = auto_fifo_en & near;
  wire trig_desc = auto_desc_en & desc_unavail;
  wire comb = either_mode ? (trig_fifo | trig_desc) : (trig_fifo & trig_desc);

  wire ev_max  = set_max | (comb & ~comb_q);
  wire ev_zero = set_zero | (auto_fifo_en & (fifo_level == '0) & nonempty_q);

  wire take     = ~pause_req & slot_v;
  wire keep_max = ev_max | (slot_v & slot_max & ~take);
  wire zero_ok  = ev_zero & ~(near & keep_max);

  wire ack      = pause_req & tx_done;
  wire done_max = ack & (pause_time == TMAX);
  wire done_0   = ack & (pause_time == '0);

  wire [EW-1:0] erx_lhs = {frame_bytes, 3'b000};
  wire [EW-1:0] erx_rhs = EW'(fifo_capacity) * EW'(erx_sel);
  wire erx_hit = (erx_sel != 3'd0) & (erx_lhs >= erx_rhs) & ~erx_fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      comb_q     <= 1'b0;
      nonempty_q <= 1'b0;
      slot_v     <= 1'b0;
      slot_max   <= 1'b0;
      pause_req  <= 1'b0;
      pause_time <= '0;
      man_max_q  <= 1'b0;
      man_zero_q <= 1'b0;
      erx_irq    <= 1'b0;
      erx_fired  <= 1'b0;
    end else begin
      comb_q     <= comb;
      nonempty_q <= (fifo_level != '0);
      man_max_q  <= set_max  | (man_max_q  & ~done_max);
      man_zero_q <= set_zero | (man_zero_q & ~done_0);

      if (zero_ok) begin
        slot_v   <= 1'b1;
        slot_max <= 1'b0;
      end else if (ev_max) begin
        slot_v   <= 1'b1;
        slot_max <= 1'b1;
      end else if (take) begin
        slot_v   <= 1'b0;
      end

      if (ack) begin
        pause_req <= 1'b0;
      end else if (take) begin
        pause_req  <= 1'b1;
        pause_time <= slot_max ? TMAX : '0;
      end

      if (frame_start) begin
        erx_fired <= 1'b0;
        erx_irq   <= 1'b0;
      end else begin
        erx_fired <= erx_fired | erx_hit;
        erx_irq   <= erx_hit;
      end
    end
  end
endmodule

// File: rtl/pause_ctrl_checks.sv
module pause_ctrl_checks #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        erx_sel,
  input logic              set_max,
  input logic              set_zero,
  input logic              tx_done,
  input logic              pause_req,
  input logic [TIME_W-1:0] pause_time,
  input logic              erx_irq,
  input logic              man_max_q,
  input logic              man_zero_q
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pause_req && !tx_done) |=> (pause_req && $stable(pause_time)));

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (pause_req && tx_done) |=> !pause_req);

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    erx_irq |=> !erx_irq);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    (erx_sel == 3'd0) |=> !erx_irq);

  p_max_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (pause_req && tx_done && pause_time == {TIME_W{1'b1}} && !set_max) |=> !man_max_q);

  p_zero_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (pause_req && tx_done && pause_time == '0 && !set_zero) |=> !man_zero_q);

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!pause_req && !erx_irq && !man_max_q && !man_zero_q));
endmodule

bind rx_pause_ctrl pause_ctrl_checks #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst(rst), .erx_sel(erx_sel), .set_max(set_max), .set_zero(set_zero),
  .tx_done(tx_done), .pause_req(pause_req), .pause_time(pause_time),
  .erx_irq(erx_irq), .man_max_q(man_max_q), .man_zero_q(man_zero_q)
);

// File: tb/test_rx_pause_ctrl.sv
module test_rx_pause_ctrl;
  localparam int CW = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] fifo_level = '0, fifo_capacity = 12'd1024, frame_bytes = '0;
  logic frame_start = 0, desc_unavail = 0, auto_fifo_en = 0, auto_desc_en = 0;
  logic either_mode = 0, set_max = 0, set_zero = 0, tx_done = 0;
  logic [5:0] near_thresh = '0;
  logic [2:0] erx_sel = '0;
  logic pause_req, erx_irq, man_max_q, man_zero_q;
  logic [15:0] pause_time;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_pause_ctrl #(.CNT_W(CW), .TIME_W(16)) i_rx_pause_ctrl (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_capacity(fifo_capacity),
    .frame_start(frame_start), .frame_bytes(frame_bytes), .desc_unavail(desc_unavail),
    .near_thresh(near_thresh), .erx_sel(erx_sel), .auto_fifo_en(auto_fifo_en),
    .auto_desc_en(auto_desc_en), .either_mode(either_mode), .set_max(set_max),
    .set_zero(set_zero), .tx_done(tx_done), .pause_req(pause_req),
    .pause_time(pause_time), .erx_irq(erx_irq), .man_max_q(man_max_q),
    .man_zero_q(man_zero_q));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; fifo_level = '0; frame_bytes = '0; frame_start = 0; desc_unavail = 0;
    auto_fifo_en = 0; auto_desc_en = 0; either_mode = 0; set_max = 0; set_zero = 0;
    tx_done = 0; near_thresh = '0; erx_sel = '0;
    step(2);
    rst = 0;
    step(1);
  endtask

  task automatic ack();
    tx_done = 1; step(1); tx_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    set_max = 1; step(1); set_max = 0; step(1);
    chk("R6 request before reset", {31'd0, pause_req}, 1);
    rst = 1; step(1);
    chk("R11 pause_req after reset", {31'd0, pause_req}, 0);
    chk("R11 man_max_q after reset", {31'd0, man_max_q}, 0);
    chk("R11 erx_irq after reset", {31'd0, erx_irq}, 0);
    rst = 0; step(3);
    chk("R11 pending slot cleared", {31'd0, pause_req}, 0);
  endtask

  task automatic t_near();
    do_reset();
    auto_fifo_en = 1; either_mode = 1; near_thresh = 6'd4;
    fifo_level = 12'd127; step(3);
    chk("R1 below level no request", {31'd0, pause_req}, 0);
    fifo_level = 12'd128; step(2);
    chk("R1 R2 at level request", {31'd0, pause_req}, 1);
    chk("R2 time FFFF", {16'd0, pause_time}, 32'hFFFF);
    step(3);
    chk("R9 held without done", {31'd0, pause_req}, 1);
    ack();
    chk("R9 drop on done", {31'd0, pause_req}, 0);
    fifo_level = 12'd200; step(5);
    chk("R2 no repeat while full", {31'd0, pause_req}, 0);
    fifo_level = 12'd100; step(2);
    fifo_level = 12'd150; step(2);
    chk("R2 re-trigger after clear", {31'd0, pause_req}, 1);
    ack();
    near_thresh = 6'd0; fifo_level = 12'd10; step(2);
    fifo_level = 12'd4000; step(4);
    chk("R1 field zero disables", {31'd0, pause_req}, 0);
  endtask

  task automatic t_empty();
    do_reset();
    auto_fifo_en = 1; near_thresh = 6'd4; fifo_level = 12'd50; step(3);
    chk("R3 no request when not empty", {31'd0, pause_req}, 0);
    fifo_level = '0; step(2);
    chk("R3 request on empty", {31'd0, pause_req}, 1);
    chk("R3 time 0000", {16'd0, pause_time}, 0);
    ack();
  endtask

  task automatic t_desc();
    do_reset();
    auto_desc_en = 1; either_mode = 1; desc_unavail = 1; step(2);
    chk("R4 R5 descriptor alone in OR mode", {31'd0, pause_req}, 1);
    chk("R4 time FFFF", {16'd0, pause_time}, 32'hFFFF);
    ack(); desc_unavail = 0; step(2);
    either_mode = 0; auto_fifo_en = 1; near_thresh = 6'd4; fifo_level = 12'd50;
    desc_unavail = 1; step(3);
    chk("R5 AND mode one source only", {31'd0, pause_req}, 0);
    fifo_level = 12'd200; step(2);
    chk("R5 AND mode both sources", {31'd0, pause_req}, 1);
    ack();
  endtask

  task automatic t_manual();
    do_reset();
    set_max = 1; step(1); set_max = 0;
    chk("R6 man_max_q set", {31'd0, man_max_q}, 1);
    step(1);
    chk("R6 manual max request", {16'd0, pause_time}, 32'hFFFF);
    step(2);
    chk("R6 bit held until sent", {31'd0, man_max_q}, 1);
    ack();
    chk("R6 self clear", {31'd0, man_max_q}, 0);
    set_zero = 1; step(1); set_zero = 0; step(1);
    chk("R7 manual zero request", {31'd0, pause_req}, 1);
    chk("R7 time 0000", {16'd0, pause_time}, 0);
    chk("R7 man_zero_q set", {31'd0, man_zero_q}, 1);
    ack();
    chk("R7 self clear", {31'd0, man_zero_q}, 0);
  endtask

  task automatic t_conflict();
    do_reset();
    auto_fifo_en = 1; either_mode = 1; near_thresh = 6'd4; fifo_level = 12'd50;
    set_max = 1; step(1); set_max = 0; step(2);
    fifo_level = 12'd200; step(1);
    set_zero = 1; step(1); set_zero = 0; step(1);
    ack();
    chk("R9 gap after done", {31'd0, pause_req}, 0);
    step(1);
    chk("R8 pending max presented", {31'd0, pause_req}, 1);
    chk("R8 zero dropped, time FFFF", {16'd0, pause_time}, 32'hFFFF);
    ack(); step(3);
    chk("R8 no trailing zero frame", {31'd0, pause_req}, 0);
    do_reset();
    auto_desc_en = 1; either_mode = 1;
    desc_unavail = 1; set_zero = 1; step(1); set_zero = 0; step(1);
    chk("R8 tie below level request", {31'd0, pause_req}, 1);
    chk("R8 tie below level zero wins", {16'd0, pause_time}, 0);
    ack(); step(3);
    chk("R8 tie leaves nothing pending", {31'd0, pause_req}, 0);
  endtask

  task automatic t_early();
    do_reset();
    erx_sel = 3'd2;
    frame_start = 1; step(1); frame_start = 0;
    frame_bytes = 12'd255; step(2);
    chk("R10 below fraction", {31'd0, erx_irq}, 0);
    frame_bytes = 12'd256; step(1);
    chk("R10 pulse at fraction", {31'd0, erx_irq}, 1);
    step(1);
    chk("R10 single cycle", {31'd0, erx_irq}, 0);
    frame_bytes = 12'd500; step(2);
    chk("R10 once per frame", {31'd0, erx_irq}, 0);
    frame_start = 1; frame_bytes = '0; step(1); frame_start = 0;
    frame_bytes = 12'd300; step(1);
    chk("R10 re-armed next frame", {31'd0, erx_irq}, 1);
    erx_sel = 3'd7; frame_start = 1; frame_bytes = '0; step(1); frame_start = 0;
    frame_bytes = 12'd895; step(2);
    chk("R10 seven eighths below", {31'd0, erx_irq}, 0);
    frame_bytes = 12'd896; step(1);
    chk("R10 seven eighths reached", {31'd0, erx_irq}, 1);
    erx_sel = 3'd0; frame_start = 1; frame_bytes = '0; step(1); frame_start = 0;
    frame_bytes = 12'd1000; step(1);
    chk("R10 disabled no pulse", {31'd0, erx_irq}, 0);
  endtask

  initial begin
    t_reset();
    t_near();
    t_empty();
    t_desc();
    t_manual();
    t_conflict();
    t_early();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule